// File: doc/BRIEF.md
# NRZI Bit-Stuffing Packet Transmitter

This block serializes a packet for a differential serial bus, one line symbol per clock. Packet bytes arrive over a valid/ready handshake and leave least significant bit first. The block puts a synchronization field in front of the data, inserts a zero after every run of six ones, and NRZI-encodes the stream. It then closes the packet with an end-of-packet marker that depends on the signalling speed. Each cycle it reports one of three line symbols (J, K or single-ended zero) together with an output-enable for the line driver.

Two inputs choose the packet format. One selects low/full-speed or high-speed signalling. The other marks a start-of-frame packet, which in high-speed mode uses a longer end marker. Both are sampled with the first byte of a packet. The packet ends when no byte is offered at a byte boundary. Clock recovery, CRC, the receive path and analog drive belong to other blocks.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: After reset, and whenever `oe_o` is low, `line_o` shows J. Symbol encoding on `line_o`: 2'b01 = J, 2'b10 = K, 2'b00 = SE0.
- R2: Every packet starts with a sync field. In low/full-speed mode it is 8 symbols, K J K J K J K K. In high-speed mode it is 32 symbols: fifteen K J pairs followed by K K. The sync begins from a J reference level.
- R3: Data bits go out LSB first. A 1 keeps the previous symbol and a 0 toggles it between J and K.
- R4: After six consecutive one bits, a stuffed 0 (a toggle) is inserted. The final 1 of the sync field counts as the first one of a run. A data 0 or a stuffed 0 clears the run.
- R5: If the last data bit completes a run of six ones, the stuffed 0 is still sent, directly before the end-of-packet marker.
- R6: The low/full-speed end marker is SE0, SE0, J, after which `oe_o` goes low. SE0 never appears in high-speed mode.
- R7: The high-speed end marker of a non-start-of-frame packet is the unstuffed bit pattern 0 followed by seven 1s. This gives eight identical symbols, each the opposite of the last symbol before the marker. `oe_o` then goes low.
- R8: The high-speed end marker of a start-of-frame packet is the unstuffed pattern 0 followed by 39 1s, which gives 40 identical symbols.
- R9: `ready_o` is high in idle and in the cycle where a byte's final bit is serialized. It is low during sync, stuffed bits and the end marker. Bytes accepted back to back produce an unbroken symbol stream. If `valid_i` is low at a byte boundary, the packet ends.
- R10: `hs_mode_i` and `sof_i` are sampled only when the first byte is accepted. Changing them during a packet has no effect on that packet's symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_mode_i | input | 1 | 1 = high-speed format, 0 = low/full-speed |
| sof_i | input | 1 | Start-of-frame packet (long high-speed end marker) |
| data_i | input | 8 | Packet byte, sent LSB first |
| valid_i | input | 1 | Byte on data_i is offered |
| ready_o | output | 1 | Byte is taken this cycle when valid_i is high |
| line_o | output | 2 | Line symbol: 01 J, 10 K, 00 SE0 |
| oe_o | output | 1 | Line driver enable |

## Verification
A stuffed bit can fall in the same cycle window as a byte boundary, or as the start of the end marker. In that case the ready pulse, or the marker, must wait one cycle behind the inserted toggle. The bench provokes this with bytes such as 0xFC, whose top six bits are ones, in both a final and a non-final position, and with 0x1F, whose run is completed by the last sync bit. A scoreboard model predicts every symbol from the rules alone and compares each driven symbol in order. It also counts the ready pulses of each packet, so a misplaced stuff bit or a misplaced handshake is reported.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;
  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10
  } sym_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_EOP
  } st_e;

  typedef enum logic [1:0] {
    EMIT_IDLE,
    EMIT_BIT,
    EMIT_SE0,
    EMIT_J
  } emit_e;
endpackage

// File: rtl/nrzi_tx_stuffer.sv
module nrzi_tx_stuffer #(
  parameter int STUFF_RUN = 6,
  localparam int RUN_W = $clog2(STUFF_RUN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_en_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic             stuff_req_o,
  output logic [RUN_W-1:0] run_o
);
  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    if (!count_en_i || !bit_valid_i) run_d = '0;
    else if (bit_i)                  run_d = run_q + 1'b1;
    else                             run_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  assign stuff_req_o = (run_q == RUN_W'(STUFF_RUN));
  assign run_o       = run_q;
endmodule

// File: rtl/nrzi_tx_line.sv
module nrzi_tx_line
  import nrzi_tx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  emit_e emit_i,
  input  logic  bit_i,
  output sym_e  line_o,
  output logic  oe_o
);
  logic level_q;  // 0 = J, 1 = K
  logic lvl_n;

  assign lvl_n = bit_i ? level_q : ~level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      line_o  <= SYM_J;
      oe_o    <= 1'b0;
    end else begin
      unique case (emit_i)
        EMIT_BIT: begin
          level_q <= lvl_n;
          line_o  <= lvl_n ? SYM_K : SYM_J;
          oe_o    <= 1'b1;
        end
        EMIT_SE0: begin
          line_o <= SYM_SE0;
          oe_o   <= 1'b1;
        end
        EMIT_J: begin
          level_q <= 1'b0;
          line_o  <= SYM_J;
          oe_o    <= 1'b1;
        end
        default: begin
          level_q <= 1'b0;
          line_o  <= SYM_J;
          oe_o    <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/nrzi_tx_ctrl.sv
module nrzi_tx_ctrl
  import nrzi_tx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int FS_SYNC_LEN    = 8,
  parameter int HS_SYNC_LEN    = 32,
  parameter int HS_EOP_LEN     = 8,
  parameter int HS_SOF_EOP_LEN = 40,
  parameter int FS_SE0_LEN     = 2,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(HS_SOF_EOP_LEN + HS_SYNC_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_mode_i,
  input  logic              sof_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              stuff_req_i,
  output logic              ready_o,
  output emit_e             emit_o,
  output logic              bit_o,
  output logic              count_en_o,
  output logic              hs_o,
  output st_e               state_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  st_e               state_q, state_d;
  logic              hs_q, hs_d, sof_q, sof_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  sync_last, eop_last;

  assign sync_last = hs_q ? CNT_W'(HS_SYNC_LEN - 1) : CNT_W'(FS_SYNC_LEN - 1);
  assign eop_last  = sof_q ? CNT_W'(HS_SOF_EOP_LEN - 1) : CNT_W'(HS_EOP_LEN - 1);

  always_comb begin
    state_d    = state_q;
    hs_d       = hs_q;
    sof_d      = sof_q;
    shreg_d    = shreg_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    ready_o    = 1'b0;
    emit_o     = EMIT_IDLE;
    bit_o      = 1'b1;
    count_en_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ready_o = 1'b1;
        if (valid_i) begin
          shreg_d = data_i;
          hs_d    = hs_mode_i;
          sof_d   = sof_i;
          cnt_d   = '0;
          idx_d   = '0;
          state_d = ST_SYNC;
        end
      end
      ST_SYNC: begin
        emit_o     = EMIT_BIT;
        count_en_o = 1'b1;
        bit_o      = (cnt_q == sync_last);
        cnt_d      = cnt_q + 1'b1;
        if (cnt_q == sync_last) begin
          cnt_d   = '0;
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        emit_o     = EMIT_BIT;
        count_en_o = 1'b1;
        if (stuff_req_i) begin
          bit_o = 1'b0;
        end else begin
          bit_o = shreg_q[idx_q];
          if (idx_q == IDX_LAST) begin
            ready_o = 1'b1;
            idx_d   = '0;
            if (valid_i) shreg_d = data_i;
            else         state_d = ST_EOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_EOP: begin
        if (stuff_req_i) begin
          // run completed by the final data bit
          emit_o     = EMIT_BIT;
          bit_o      = 1'b0;
          count_en_o = 1'b1;
        end else if (hs_q) begin
          emit_o = EMIT_BIT;
          bit_o  = (cnt_q != '0);
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == eop_last) state_d = ST_IDLE;
        end else begin
          emit_o = (cnt_q < CNT_W'(FS_SE0_LEN)) ? EMIT_SE0 : EMIT_J;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(FS_SE0_LEN)) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hs_q    <= 1'b0;
      sof_q   <= 1'b0;
      shreg_q <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      hs_q    <= hs_d;
      sof_q   <= sof_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hs_o    = hs_q;
  assign state_o = state_q;
endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx
  import nrzi_tx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int STUFF_RUN      = 6,
  parameter int FS_SYNC_LEN    = 8,
  parameter int HS_SYNC_LEN    = 32,
  parameter int HS_EOP_LEN     = 8,
  parameter int HS_SOF_EOP_LEN = 40,
  localparam int RUN_W = $clog2(STUFF_RUN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_mode_i,
  input  logic              sof_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [1:0]        line_o,
  output logic              oe_o
);
  emit_e            emit;
  logic             tx_bit, count_en, stuff_req, hs_lat;
  logic [RUN_W-1:0] run_cnt;
  st_e              state;
  sym_e             line_sym;

  nrzi_tx_ctrl #(
    .DATA_W(DATA_W), .FS_SYNC_LEN(FS_SYNC_LEN), .HS_SYNC_LEN(HS_SYNC_LEN),
    .HS_EOP_LEN(HS_EOP_LEN), .HS_SOF_EOP_LEN(HS_SOF_EOP_LEN), .FS_SE0_LEN(2)
  ) u_ctrl (
    .clk_i, .rst_ni, .hs_mode_i, .sof_i, .data_i, .valid_i,
    .stuff_req_i(stuff_req),
    .ready_o,
    .emit_o(emit),
    .bit_o(tx_bit),
    .count_en_o(count_en),
    .hs_o(hs_lat),
    .state_o(state)
  );

  nrzi_tx_stuffer #(.STUFF_RUN(STUFF_RUN)) u_stuff (
    .clk_i, .rst_ni,
    .count_en_i(count_en),
    .bit_valid_i(emit == EMIT_BIT),
    .bit_i(tx_bit),
    .stuff_req_o(stuff_req),
    .run_o(run_cnt)
  );

  nrzi_tx_line u_line (
    .clk_i, .rst_ni,
    .emit_i(emit),
    .bit_i(tx_bit),
    .line_o(line_sym),
    .oe_o
  );

  assign line_o = line_sym;
endmodule

// File: rtl/nrzi_stuff_tx_chk.sv
module nrzi_stuff_tx_chk
  import nrzi_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6,
  localparam int RUN_W = $clog2(STUFF_RUN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       line_i,
  input logic             oe_i,
  input logic             ready_i,
  input logic             hs_i,
  input logic             stuff_req_i,
  input logic [RUN_W-1:0] run_i,
  input st_e              state_i
);
  // R1
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> line_i == SYM_J);

  // R2
  sync_first_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_i) |-> line_i == SYM_K);

  // R4
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i <= RUN_W'(STUFF_RUN));

  // R4
  stuff_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_req_i |=> run_i == '0);

  // R9
  ready_stuff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_req_i && state_i != ST_IDLE |-> !ready_i);

  // R9
  ready_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SYNC || state_i == ST_EOP) |-> !ready_i);

  // R6
  se0_fs_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i && line_i == SYM_SE0 && state_i == ST_EOP |-> !hs_i);

  // R6
  end_not_se0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_i) |-> $past(line_i) != SYM_SE0);
endmodule

bind nrzi_stuff_tx nrzi_stuff_tx_chk #(.STUFF_RUN(STUFF_RUN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_o), .oe_i(oe_o),
  .ready_i(ready_o), .hs_i(hs_lat), .stuff_req_i(stuff_req),
  .run_i(run_cnt), .state_i(state)
);

// File: tb/nrzi_stuff_tx_tb_top.sv
`timescale 1ns/1ps
module nrzi_stuff_tx_tb_top;
  localparam logic [1:0] S_SE0 = 2'b00, S_J = 2'b01, S_K = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_mode = 1'b0, sof = 1'b0, valid = 1'b0;
  logic [7:0] data = '0;
  logic       ready, oe;
  logic [1:0] line;

  int checks = 0, failures = 0, rdy_cnt = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic       m_level;
  int         m_ones;

  always #4 clk = ~clk;

  nrzi_stuff_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hs_mode_i(hs_mode), .sof_i(sof),
    .data_i(data), .valid_i(valid), .ready_o(ready), .line_o(line), .oe_o(oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] lv(input logic l);
    return l ? S_K : S_J;
  endfunction

  task automatic push(input logic [1:0] s, input string t);
    exp_q.push_back(s);
    tag_q.push_back(t);
  endtask

  task automatic mbit(input bit b, input string t, input string st);
    if (!b) m_level = ~m_level;
    push(lv(m_level), t);
    m_ones = b ? m_ones + 1 : 0;
    if (m_ones == 6) begin
      m_level = ~m_level;
      push(lv(m_level), st);
      m_ones = 0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (oe && ready) rdy_cnt++;
      if (oe) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected symbol", int'(line), -1);
        end else begin
          logic [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(line == e, t, int'(line), int'(e));
        end
      end else begin
        chk(line == S_J, "R1 idle level", int'(line), int'(S_J));
      end
    end
  end

  task automatic send_pkt(input bit hs, input bit sf, input int n,
                          input logic [7:0] p[4], input bit flip, input string ovr);
    int slen, elen;
    string tg;
    m_level = 1'b0;
    m_ones  = 0;
    slen = hs ? 32 : 8;
    for (int i = 0; i < slen; i++) mbit(i == slen - 1, ovr != "" ? ovr : "R2", ovr != "" ? ovr : "R4");
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++)
        mbit(p[k][b], ovr != "" ? ovr : "R3",
             ovr != "" ? ovr : ((k == n - 1 && b == 7) ? "R5" : "R4"));
    if (!hs) begin
      tg = ovr != "" ? ovr : "R6";
      push(S_SE0, tg); push(S_SE0, tg); push(S_J, tg);
    end else begin
      elen = sf ? 40 : 8;
      tg = ovr != "" ? ovr : (sf ? "R8" : "R7");
      m_level = ~m_level;
      for (int i = 0; i < elen; i++) push(lv(m_level), tg);
    end
    // drive
    @(negedge clk);
    rdy_cnt = 0;
    hs_mode = hs; sof = sf; data = p[0]; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(posedge clk);
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      if (flip && k == 1) begin hs_mode = ~hs; sof = ~sf; end
      data = p[k];
      while (!ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    if (flip && n == 1) begin hs_mode = ~hs; sof = ~sf; end
    valid = 1'b0;
    while (exp_q.size() != 0 || oe) @(negedge clk);
    // R9: one ready pulse per byte boundary plus the idle cycle showing the last symbol
    chk(rdy_cnt == n + 1, "R9 ready pulses", rdy_cnt, n + 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe == 1'b0, "R1 reset oe", int'(oe), 0);
    chk(line == S_J, "R1 reset line", int'(line), int'(S_J));
    chk(ready == 1'b1, "R9 reset ready", int'(ready), 1);

    send_pkt(1'b0, 1'b0, 1, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1'b0, "");   // R2 R3 R6
    send_pkt(1'b0, 1'b0, 1, '{8'h1F, 8'h00, 8'h00, 8'h00}, 1'b0, "");   // R4 run from sync
    send_pkt(1'b0, 1'b0, 1, '{8'hFC, 8'h00, 8'h00, 8'h00}, 1'b0, "");   // R5 stuff before end
    send_pkt(1'b0, 1'b0, 3, '{8'hFC, 8'h3F, 8'h00, 8'h00}, 1'b0, "");   // R4 R9 stuff at boundary
    send_pkt(1'b1, 1'b0, 2, '{8'h2D, 8'hFF, 8'h00, 8'h00}, 1'b0, "");   // R7
    send_pkt(1'b1, 1'b1, 3, '{8'hA5, 8'h5A, 8'h01, 8'h00}, 1'b0, "");   // R8
    send_pkt(1'b1, 1'b0, 4, '{8'hFC, 8'h00, 8'hFF, 8'h7E}, 1'b1, "R10"); // R10 mode held
    send_pkt(1'b0, 1'b1, 2, '{8'h80, 8'hFC, 8'h00, 8'h00}, 1'b1, "R10"); // R10 sof ignored in fs

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule